// File: doc/BRIEF.md
# Unlock-Guarded Flash Command Decoder

This block sits behind the write port of a flash controller. It watches the stream of bus write cycles and recognises the multi-cycle command sequences used to drive a flash array. Each write arrives as a one-cycle strobe. With the strobe come a word address, an extra byte-lane address bit and a data word. Every command except the single-write ones must be preceded by a two-write unlock handshake at fixed addresses. The erase command needs a second handshake after its setup byte. A recognised command leaves the block as a registered one-cycle pulse, together with the address and data of the write that completed it.

The decoder is a state machine with seven states:
- `ST_IDLE`: no sequence in progress.
- `ST_UNLOCK_A`: first key seen.
- `ST_UNLOCK_B`: both keys seen, waiting for the command byte.
- `ST_PROG_WAIT`: program armed, waiting for the target write.
- `ST_ERASE_SETUP`: erase setup seen.
- `ST_ERASE_UNL_A`: first key of the second handshake seen.
- `ST_ERASE_UNL_B`: second handshake complete, waiting for the erase kind.

A write that advances a sequence moves one state forward. A write that completes a command returns to idle and issues the pulse. Every other write returns to idle. A clock with no write leaves the state alone.

The `byte_mode` input selects how the unlock addresses are matched. An `erase_pending` input, driven by the embedded-operation logic, marks that a sector erase is running or suspended, and so enables the single-write suspend and resume commands. Command bytes are taken from data bits [7:0].

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all seven command pulses are low and the decoder is in `ST_IDLE`.
- R2: In word mode, the first unlock address matches when address bits [10:0] equal 555h, and the second when they equal 2AAh. Address bits above bit 10 and the byte-lane bit are ignored.
- R3: In byte mode, the first unlock address is byte address AAAh, meaning bits [10:0] = 555h with byte-lane bit 0. The second is byte address 555h, meaning bits [10:0] = 2AAh with byte-lane bit 1.
- R4: The handshake is AAh at the first address, then 55h at the second. A third write at the first address then decodes as follows: F0h gives a reset pulse, and 90h gives an autoselect pulse.
- R5: A third write of A0h arms programming. The next write, at any address and with any data (F0h included), produces a program pulse carrying that write's address, byte-lane bit and full data word.
- R6: A third write of 80h, then AAh at the first address, 55h at the second address, and 10h at the first address, produces a chip-erase pulse.
- R7: The same five writes ended by 30h at any address produce a sector-erase pulse, and `cmd_addr` carries the address of that sixth write.
- R8: Outside `ST_PROG_WAIT`, a write whose command byte is F0h, at any address, produces a reset pulse and returns the decoder to `ST_IDLE`.
- R9: In `ST_IDLE` with `erase_pending` high, a single write of B0h at any address produces a suspend pulse, and a single write of 30h produces a resume pulse. With `erase_pending` low, neither write produces a pulse.
- R10: A write that does not match the expected next step returns the decoder to `ST_IDLE` and produces no pulse. A following full sequence is then decoded normally.
- R11: A command pulse is high for exactly the cycle after the completing write's strobe, at most one pulse is high at a time, and the captured address and data are valid in that cycle.
- R12: A clock cycle without a write strobe changes neither the sequence state nor the pulse outputs, beyond ending a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| erase_pending | input | 1 | A sector erase is running or suspended |
| wr_valid | input | 1 | One-cycle write strobe (latched write cycle) |
| wr_addr | input | ADDR_W (20) | Word address of the write |
| wr_lsb | input | 1 | Byte-lane address bit, used in byte mode |
| wr_data | input | DATA_W (16) | Write data; command byte in bits [7:0] |
| cmd_reset | output | 1 | Reset-to-read pulse |
| cmd_autosel | output | 1 | Autoselect entry pulse |
| cmd_program | output | 1 | Program pulse |
| cmd_chip_erase | output | 1 | Chip-erase pulse |
| cmd_sector_erase | output | 1 | Sector-erase pulse |
| cmd_suspend | output | 1 | Erase-suspend pulse |
| cmd_resume | output | 1 | Erase-resume pulse |
| cmd_addr | output | ADDR_W (20) | Address of the completing write |
| cmd_lsb | output | 1 | Byte-lane bit of the completing write |
| cmd_data | output | DATA_W (16) | Data of the completing write |

## Verification
The bench builds the block with its defaults: a 20-bit word address, a 16-bit data word and an 11-bit unlock compare field. This leaves nine upper address bits that the bench fills at random during unlock writes, so any dependence on them would break a sequence. The 16-bit data word lets the bench check that a program write carrying F0h, or an arbitrary upper byte, is captured whole rather than decoded as a reset. Random writes are drawn mostly from the command bytes and the two unlock addresses, so partial sequences, broken handshakes and mode flips between writes occur often. The bench interleaves these with complete sequences in both address modes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK_A,
        ST_UNLOCK_B,
        ST_PROG_WAIT,
        ST_ERASE_SETUP,
        ST_ERASE_UNL_A,
        ST_ERASE_UNL_B
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_AUTOSEL,
        CMD_PROGRAM,
        CMD_CHIP_ERASE,
        CMD_SECTOR_ERASE,
        CMD_SUSPEND,
        CMD_RESUME
    } cmd_kind_e;

    localparam int          OP_W          = 8;
    localparam int          NUM_CMDS      = 7;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  OP_RESET      = 8'hF0;
    localparam logic [7:0]  OP_AUTOSEL    = 8'h90;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]  OP_ERASE_SET  = 8'h80;
    localparam logic [7:0]  OP_CHIP       = 8'h10;
    localparam logic [7:0]  OP_SECTOR     = 8'h30;
    localparam logic [7:0]  OP_SUSPEND    = 8'hB0;
    localparam logic [7:0]  OP_RESUME     = 8'h30;

    // Alternating bit pattern: bits with (index % 2) == odd_sel are set.
    function automatic logic [31:0] alt_bits(input int width, input int odd_sel);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < width; i++) begin
            if ((i % 2) == odd_sel) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/unlock_addr_match.sv
module unlock_addr_match #(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] addr_low,
    input  logic             lane_bit,
    input  logic             byte_mode,
    output logic             hit_first,
    output logic             hit_second
);
    import flash_cmd_pkg::*;

    localparam logic [CMP_W-1:0] FIRST_PAT  = CMP_W'(alt_bits(CMP_W, 0));
    localparam logic [CMP_W-1:0] SECOND_PAT = CMP_W'(alt_bits(CMP_W, 1));

    logic low_first;
    logic low_second;

    assign low_first  = (addr_low == FIRST_PAT);
    assign low_second = (addr_low == SECOND_PAT);

    // Byte mode appends the lane bit below the word address.
    always_comb begin
        if (byte_mode) begin
            hit_first  = low_first  && !lane_bit;
            hit_second = low_second &&  lane_bit;
        end else begin
            hit_first  = low_first;
            hit_second = low_second;
        end
    end

    always_comb begin
        assert (!(hit_first && hit_second)) else $error("AST_ADDR_EXCLUSIVE"); // R2
    end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       hit_first,
    input  logic                       hit_second,
    input  logic [7:0]                 op,
    input  logic                       erase_pending,
    output flash_cmd_pkg::cmd_kind_e   issue
);
    import flash_cmd_pkg::*;

    seq_state_e state;
    seq_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        issue     = CMD_NONE;
        if (wr_valid) begin
            state_nxt = ST_IDLE;
            if (state != ST_PROG_WAIT && op == OP_RESET) begin
                issue = CMD_RESET;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (erase_pending && op == OP_SUSPEND)      issue = CMD_SUSPEND;
                        else if (erase_pending && op == OP_RESUME)  issue = CMD_RESUME;
                        else if (hit_first && op == KEY_FIRST)      state_nxt = ST_UNLOCK_A;
                    end
                    ST_UNLOCK_A: begin
                        if (hit_second && op == KEY_SECOND) state_nxt = ST_UNLOCK_B;
                    end
                    ST_UNLOCK_B: begin
                        if (hit_first) begin
                            if (op == OP_AUTOSEL)        issue = CMD_AUTOSEL;
                            else if (op == OP_PROGRAM)   state_nxt = ST_PROG_WAIT;
                            else if (op == OP_ERASE_SET) state_nxt = ST_ERASE_SETUP;
                        end
                    end
                    ST_PROG_WAIT: begin
                        issue = CMD_PROGRAM;
                    end
                    ST_ERASE_SETUP: begin
                        if (hit_first && op == KEY_FIRST) state_nxt = ST_ERASE_UNL_A;
                    end
                    ST_ERASE_UNL_A: begin
                        if (hit_second && op == KEY_SECOND) state_nxt = ST_ERASE_UNL_B;
                    end
                    ST_ERASE_UNL_B: begin
                        if (hit_first && op == OP_CHIP) issue = CMD_CHIP_ERASE;
                        else if (op == OP_SECTOR)       issue = CMD_SECTOR_ERASE;
                    end
                    default: state_nxt = ST_IDLE;
                endcase
            end
        end
    end

    AST_QUIET_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(state)); // R12

    AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG_WAIT) |-> $past(state == ST_UNLOCK_B || state == ST_PROG_WAIT)); // R5

    AST_ERASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_UNL_B) |-> $past(state == ST_ERASE_UNL_A || state == ST_ERASE_UNL_B)); // R6

    AST_UNLOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNLOCK_B) |-> $past(state == ST_UNLOCK_A || state == ST_UNLOCK_B)); // R4

endmodule

// File: rtl/cmd_pulse_reg.sv
module cmd_pulse_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  flash_cmd_pkg::cmd_kind_e  issue,
    input  logic [ADDR_W-1:0]         addr_in,
    input  logic                      lsb_in,
    input  logic [DATA_W-1:0]         data_in,
    output logic [flash_cmd_pkg::NUM_CMDS-1:0] pulses,
    output logic [ADDR_W-1:0]         addr_q,
    output logic                      lsb_q,
    output logic [DATA_W-1:0]         data_q
);
    import flash_cmd_pkg::*;

    logic [NUM_CMDS-1:0] pulse_d;

    // Pulse bit k corresponds to command kind k+1.
    for (genvar k = 0; k < NUM_CMDS; k++) begin : g_dec
        assign pulse_d[k] = (issue == cmd_kind_e'(k + 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses <= '0;
            addr_q <= '0;
            lsb_q  <= 1'b0;
            data_q <= '0;
        end else begin
            pulses <= pulse_d;
            if (issue != CMD_NONE) begin
                addr_q <= addr_in;
                lsb_q  <= lsb_in;
                data_q <= data_in;
            end
        end
    end

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses)); // R11

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              erase_pending,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_reset,
    output logic              cmd_autosel,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lsb,
    output logic [DATA_W-1:0] cmd_data
);
    import flash_cmd_pkg::*;

    logic                hit_first;
    logic                hit_second;
    cmd_kind_e           issue;
    logic [NUM_CMDS-1:0] pulses;

    unlock_addr_match #(.CMP_W(CMP_W)) u_match (
        .addr_low   (wr_addr[CMP_W-1:0]),
        .lane_bit   (wr_lsb),
        .byte_mode  (byte_mode),
        .hit_first  (hit_first),
        .hit_second (hit_second)
    );

    cmd_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .hit_first     (hit_first),
        .hit_second    (hit_second),
        .op            (wr_data[OP_W-1:0]),
        .erase_pending (erase_pending),
        .issue         (issue)
    );

    cmd_pulse_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .addr_in (wr_addr),
        .lsb_in  (wr_lsb),
        .data_in (wr_data),
        .pulses  (pulses),
        .addr_q  (cmd_addr),
        .lsb_q   (cmd_lsb),
        .data_q  (cmd_data)
    );

    assign cmd_reset        = pulses[0];
    assign cmd_autosel      = pulses[1];
    assign cmd_program      = pulses[2];
    assign cmd_chip_erase   = pulses[3];
    assign cmd_sector_erase = pulses[4];
    assign cmd_suspend      = pulses[5];
    assign cmd_resume       = pulses[6];

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(wr_valid)); // R11

    AST_SECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sector_erase |-> (cmd_addr == $past(wr_addr))); // R7

    AST_PROGRAM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_program |-> (cmd_data == $past(wr_data))); // R5

    AST_SUSPEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_suspend || cmd_resume) |-> $past(erase_pending)); // R9

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_mode = 1'b0;
    logic          erase_pending = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_lsb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic cmd_reset, cmd_autosel, cmd_program, cmd_chip_erase;
    logic cmd_sector_erase, cmd_suspend, cmd_resume;
    logic [AW-1:0] cmd_addr;
    logic          cmd_lsb;
    logic [DW-1:0] cmd_data;

    int checks = 0;
    int fails  = 0;
    int ms     = 0; // model state: 0 idle,1 keyA,2 keyB,3 prog,4 eset,5 ekeyA,6 ekeyB
    bit done   = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .erase_pending(erase_pending),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data),
        .cmd_reset(cmd_reset), .cmd_autosel(cmd_autosel), .cmd_program(cmd_program),
        .cmd_chip_erase(cmd_chip_erase), .cmd_sector_erase(cmd_sector_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .cmd_addr(cmd_addr), .cmd_lsb(cmd_lsb), .cmd_data(cmd_data)
    );

    function automatic logic [6:0] pulse_vec();
        return {cmd_reset, cmd_autosel, cmd_program, cmd_chip_erase,
                cmd_sector_erase, cmd_suspend, cmd_resume};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_first(logic [AW-1:0] a, logic l, logic bm);
        return (a[10:0] == 11'h555) && (!bm || l == 1'b0);
    endfunction

    function automatic bit is_second(logic [AW-1:0] a, logic l, logic bm);
        return (a[10:0] == 11'h2AA) && (!bm || l == 1'b1);
    endfunction

    // Expected kind: 0 none,1 reset,2 autosel,3 program,4 chip,5 sector,6 suspend,7 resume
    function automatic int model(logic [AW-1:0] a, logic l, logic [DW-1:0] d, logic bm, logic ep);
        int k = 0;
        int s = ms;
        logic [7:0] b = d[7:0];
        ms = 0;
        if (s == 3) k = 3;
        else if (b == 8'hF0) k = 1;
        else case (s)
            0: if (ep && b == 8'hB0) k = 6;
               else if (ep && b == 8'h30) k = 7;
               else if (is_first(a, l, bm) && b == 8'hAA) ms = 1;
            1: if (is_second(a, l, bm) && b == 8'h55) ms = 2;
            2: if (is_first(a, l, bm)) begin
                   if (b == 8'h90) k = 2;
                   else if (b == 8'hA0) ms = 3;
                   else if (b == 8'h80) ms = 4;
               end
            4: if (is_first(a, l, bm) && b == 8'hAA) ms = 5;
            5: if (is_second(a, l, bm) && b == 8'h55) ms = 6;
            6: if (is_first(a, l, bm) && b == 8'h10) k = 4;
               else if (b == 8'h30) k = 5;
            default: ;
        endcase
        return k;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            1: return "R8/R4 reset";
            2: return "R4 autoselect";
            3: return "R5 program";
            4: return "R6 chip erase";
            5: return "R7 sector erase";
            6: return "R9 suspend";
            7: return "R9 resume";
            default: return "R10 no command";
        endcase
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic l, input logic [DW-1:0] d);
        int k;
        logic [6:0] ev;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_lsb = l; wr_data = d;
        k = model(a, l, d, byte_mode, erase_pending);
        @(negedge clk);
        wr_valid = 1'b0;
        ev = (k == 0) ? 7'b0 : (7'b1000000 >> (k - 1));
        chk({tag_of(k), " R11 pulse"}, 64'(pulse_vec()), 64'(ev));
        if (k != 0) begin
            chk({tag_of(k), " R11 addr"}, 64'(cmd_addr), 64'(a));
            chk({tag_of(k), " R11 lsb"},  64'(cmd_lsb),  64'(l));
            chk({tag_of(k), " R11 data"}, 64'(cmd_data), 64'(d));
        end
        @(negedge clk);
        chk("R12 pulse ends without write", 64'(pulse_vec()), 64'd0);
    endtask

    function automatic logic [AW-1:0] rhi();
        return AW'($urandom) & ~AW'(11'h7FF);
    endfunction

    // Unlock address: which=0 first, 1 second; returns {addr, lsb}
    function automatic logic [AW:0] uaddr(int which, logic bm);
        logic [AW-1:0] a = rhi() | AW'(which == 0 ? 11'h555 : 11'h2AA);
        logic l = bm ? logic'(which) : logic'($urandom & 1);
        return {a, l};
    endfunction

    task automatic unlock();
        logic [AW:0] u;
        u = uaddr(0, byte_mode); wr(u[AW:1], u[0], 16'h00AA);
        u = uaddr(1, byte_mode); wr(u[AW:1], u[0], 16'h0055);
    endtask

    task automatic third(input logic [7:0] op);
        logic [AW:0] u;
        u = uaddr(0, byte_mode); wr(u[AW:1], u[0], {8'($urandom), op});
    endtask

    task automatic full_seq(input int kind);
        logic [AW:0] u;
        unlock();
        case (kind)
            0: third(8'hF0);
            1: third(8'h90);
            2: begin third(8'hA0); wr(AW'($urandom), 1'($urandom), DW'($urandom)); end
            default: begin
                third(8'h80);
                unlock();
                if (kind == 3) third(8'h10);
                else wr(AW'($urandom), 1'($urandom), 16'h0030);
            end
        endcase
        u = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset pulses", 64'(pulse_vec()), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'(pulse_vec()), 64'd0);

        // Directed: word mode with junk upper bits (R2)
        byte_mode = 0;
        wr(20'hFF555, 1'b1, 16'h00AA); wr(20'h3A2AA, 1'b0, 16'h0055); wr(20'h80555, 1'b0, 16'h0090);
        // Byte mode (R3): wrong lane bit breaks the handshake
        byte_mode = 1;
        wr(20'h00555, 1'b0, 16'h00AA); wr(20'h002AA, 1'b0, 16'h0055); wr(20'h00555, 1'b0, 16'h0090);
        wr(20'h00555, 1'b0, 16'h00AA); wr(20'h002AA, 1'b1, 16'h0055); wr(20'h00555, 1'b0, 16'h0090);
        // Program data of F0h is data, not reset (R5)
        full_seq(2);
        unlock(); third(8'hA0); wr(20'h12345, 1'b1, 16'hA5F0);
        // Chip and sector erase (R6, R7)
        byte_mode = 0;
        full_seq(3); full_seq(4);
        // Chip-erase byte at non-unlock address gives nothing (R10)
        unlock(); third(8'h80); unlock(); wr(20'h00123, 1'b0, 16'h0010);
        // Reset mid-sequence (R8)
        unlock(); wr(20'h54321, 1'b0, 16'h00F0);
        // Suspend/resume gating (R9)
        wr(20'h00001, 1'b0, 16'h00B0); wr(20'h00002, 1'b0, 16'h0030);
        erase_pending = 1;
        wr(20'h00001, 1'b0, 16'h00B0); wr(20'h00002, 1'b0, 16'h0030);
        erase_pending = 0;

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            int m = int'($urandom % 4);
            if ($urandom % 8 == 0) byte_mode = 1'($urandom);
            if ($urandom % 8 == 0) erase_pending = 1'($urandom);
            if (m == 0) begin
                full_seq(int'($urandom % 5));
            end else begin
                logic [7:0] pool[9] = '{8'hAA, 8'h55, 8'hF0, 8'h90, 8'hA0, 8'h80, 8'h10, 8'h30, 8'hB0};
                logic [AW:0] u;
                logic [7:0] b = ($urandom % 6 == 0) ? 8'($urandom) : pool[$urandom % 9];
                int sel = int'($urandom % 3);
                u = (sel == 2) ? {AW'($urandom), 1'($urandom)} : uaddr(sel, 1'($urandom));
                wr(u[AW:1], u[0], {8'($urandom), b});
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule